// File: doc/BRIEF.md
# Level-Compare Interrupt Entry Unit

This unit sits on the processor side of a prioritized interrupt scheme. Devices present a 3-bit encoded request level, where zero means that nothing is pending. The processor status holds its own 3-bit priority level. When the pipeline signals an instruction boundary, the unit compares the two levels. It takes the request only if the incoming level is strictly above the current one.

After it accepts a request, the unit runs a vectored acknowledge handshake. It raises an acknowledge strobe and drives the accepted level on its address lines. It then waits for the device to report ready and to supply a vector on the data bus. When the vector arrives, the unit does four things:
- It pushes the interrupted PC and the old status onto a small save stack.
- It sets the priority level to the accepted level.
- It switches to supervisor privilege.
- It emits a redirect pulse whose target is the vector base plus the vector.

A return command pops the stack. This restores the previous status, including its priority level, and redirects to the saved PC.

Two error flags guard the handshake and the stack:
- If the device does not answer within a bounded number of cycles, the handshake is abandoned and a sticky abort flag is set.
- If a request would nest deeper than the stack holds, the request is refused and a sticky overflow flag is set.

Top module: `lia_entry_unit`

## Requirements
- R1: Out of synchronous reset, the priority level is 0 and privilege is user (supervisor=0). The acknowledge strobe, acknowledge address, redirect pulse, abort flag and overflow flag are all 0.
- R2: A request is accepted only when `insn_boundary` is 1 and `irq_level` is strictly greater than `cur_ipl`. A level of 0, a level equal to or below `cur_ipl`, or any level with `insn_boundary` at 0 leaves `ack_strobe` at 0.
- R3: In the cycle after the accepting clock edge, `ack_strobe` is 1 and `ack_addr` carries the accepted level. Both hold until the device answers or the timeout expires.
- R4: `dev_ready` sampled high during the strobe yields a one-cycle `redirect` pulse in the following cycle, with `target_pc` = `vec_base` + zero-extended `dev_vector`. The strobe drops in that same cycle.
- R5: The same edge sets `cur_ipl` to the accepted level and `supervisor` to 1. It pushes the PC sampled at acceptance, together with the old status, onto the save stack.
- R6: `rte` in an idle cycle with a non-empty stack pops the top entry. In the next cycle `redirect` pulses with `target_pc` equal to the saved PC, and `cur_ipl` and `supervisor` return to their saved values. `rte` with an empty stack changes nothing and gives no redirect.
- R7: The stack nests up to DEPTH entries. An acceptable request arriving while the stack is full is refused (no strobe), and `stack_overflow` is set and stays set until reset.
- R8: If `dev_ready` stays low for ACK_TIMEOUT strobe cycles, the strobe drops, `timeout_abort` is set and stays set until reset, and the status is left unchanged.
- R9: When `rte` and an acceptable request arrive in the same idle cycle, the return is served and the request is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_level | input | 3 | Encoded request level, 0 = none |
| insn_boundary | input | 1 | Current instruction is complete |
| pc_in | input | PC_W | PC to resume at after the handler |
| vec_base | input | PC_W | Vector base address |
| rte | input | 1 | Return-from-exception command |
| dev_ready | input | 1 | Device has placed its vector |
| dev_vector | input | VEC_W | Vector from the device |
| ack_strobe | output | 1 | Acknowledge cycle active |
| ack_addr | output | 3 | Level being acknowledged |
| redirect | output | 1 | One-cycle PC load pulse |
| target_pc | output | PC_W | PC to load |
| cur_ipl | output | 3 | Current priority level |
| supervisor | output | 1 | Privilege state |
| timeout_abort | output | 1 | Sticky acknowledge timeout flag |
| stack_overflow | output | 1 | Sticky nesting overflow flag |

## Verification
The bench builds the unit with a 16-bit PC, an 8-bit vector, a four-entry stack and an acknowledge timeout of 8 cycles. The short timeout lets the abort path be reached in a handful of cycles. The four-entry stack can be filled with levels 1 to 4, which still leaves level 5 free as a legal request to probe overflow. The deepest unwinding and the return on an empty stack follow directly after that.

// File: rtl/lia_pkg.sv
package lia_pkg;
    localparam int LVL_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } lia_state_t;

    typedef struct packed {
        logic             sup;
        logic [LVL_W-1:0] ipl;
    } lia_status_t;

    localparam int STATUS_W = LVL_W + 1;

    function automatic logic level_wins(input logic [LVL_W-1:0] req,
                                        input logic [LVL_W-1:0] cur);
        return req > cur;
    endfunction
endpackage

// File: rtl/lia_save_stack.sv
module lia_save_stack #(
    parameter int W     = 20,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;

    assign full  = (ptr == PW'(DEPTH));
    assign empty = (ptr == '0);
    assign rdata = mem[IW'(ptr - PW'(1))];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !full) begin
            mem[IW'(ptr)] <= wdata;
            ptr <= ptr + PW'(1);
        end else if (pop && !empty) begin
            ptr <= ptr - PW'(1);
        end
    end

    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/lia_ack_timer.sv
module lia_ack_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ready,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    assign expire = run && !ready && (cnt == CW'(TIMEOUT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || ready) cnt <= '0;
        else if (!expire)         cnt <= cnt + CW'(1);
        else                      cnt <= '0;
    end

    a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(TIMEOUT));
endmodule

// File: rtl/lia_entry_unit.sv
module lia_entry_unit
    import lia_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int VEC_W       = 8,
    parameter int DEPTH       = 4,
    parameter int ACK_TIMEOUT = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LVL_W-1:0]     irq_level,
    input  logic                 insn_boundary,
    input  logic [PC_W-1:0]      pc_in,
    input  logic [PC_W-1:0]      vec_base,
    input  logic                 rte,
    input  logic                 dev_ready,
    input  logic [VEC_W-1:0]     dev_vector,
    output logic                 ack_strobe,
    output logic [LVL_W-1:0]     ack_addr,
    output logic                 redirect,
    output logic [PC_W-1:0]      target_pc,
    output logic [LVL_W-1:0]     cur_ipl,
    output logic                 supervisor,
    output logic                 timeout_abort,
    output logic                 stack_overflow
);
    localparam int ENTRY_W = PC_W + STATUS_W;

    lia_state_t       st;
    lia_status_t      stat;
    logic [LVL_W-1:0] lvl_q;
    logic [PC_W-1:0]  pc_q;

    logic               req_ok, do_push, do_pop, expire, stk_full, stk_empty;
    logic [ENTRY_W-1:0] stk_rdata;
    lia_status_t        saved_stat;
    logic [PC_W-1:0]    saved_pc;

    assign req_ok  = insn_boundary && level_wins(irq_level, stat.ipl);
    assign do_push = (st == ST_ACK) && dev_ready;
    assign do_pop  = (st == ST_IDLE) && rte && !stk_empty;

    assign saved_pc   = stk_rdata[ENTRY_W-1 -: PC_W];
    assign saved_stat = lia_status_t'(stk_rdata[STATUS_W-1:0]);

    lia_save_stack #(.W(ENTRY_W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (do_push),
        .pop   (do_pop),
        .wdata ({pc_q, stat}),
        .rdata (stk_rdata),
        .full  (stk_full),
        .empty (stk_empty)
    );

    lia_ack_timer #(.TIMEOUT(ACK_TIMEOUT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (st == ST_ACK),
        .ready  (dev_ready),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= ST_IDLE;
            stat           <= '0;
            lvl_q          <= '0;
            pc_q           <= '0;
            redirect       <= 1'b0;
            target_pc      <= '0;
            timeout_abort  <= 1'b0;
            stack_overflow <= 1'b0;
        end else begin
            redirect <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (do_pop) begin
                        stat      <= saved_stat;
                        target_pc <= saved_pc;
                        redirect  <= 1'b1;
                    end else if (req_ok) begin
                        if (stk_full) begin
                            stack_overflow <= 1'b1;
                        end else begin
                            st    <= ST_ACK;
                            lvl_q <= irq_level;
                            pc_q  <= pc_in;
                        end
                    end
                end
                ST_ACK: begin
                    if (dev_ready) begin
                        stat.sup  <= 1'b1;
                        stat.ipl  <= lvl_q;
                        target_pc <= vec_base + PC_W'(dev_vector);
                        redirect  <= 1'b1;
                        st        <= ST_IDLE;
                    end else if (expire) begin
                        timeout_abort <= 1'b1;
                        st            <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ack_strobe = (st == ST_ACK);
    assign ack_addr   = (st == ST_ACK) ? lvl_q : '0;
    assign cur_ipl    = stat.ipl;
    assign supervisor = stat.sup;

    a_r3_addr_above_ipl: assert property (@(posedge clk) disable iff (rst)
        ack_strobe |-> (ack_addr > cur_ipl));
    a_r2_strobe_from_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_strobe) |-> $past(insn_boundary));
    a_r5_level_raised: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && dev_ready) |=> (supervisor && cur_ipl == $past(ack_addr)));
    a_r4_redirect_after_ready: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && dev_ready) |=> (redirect && !ack_strobe));
    a_r8_abort_sticky: assert property (@(posedge clk) disable iff (rst)
        timeout_abort |=> timeout_abort);
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        stack_overflow |=> stack_overflow);
endmodule

// File: tb/lia_entry_unit_bench.sv
module lia_entry_unit_bench;
    localparam int PC_W = 16;
    localparam int VEC_W = 8;
    localparam int DEPTH = 4;
    localparam int TMO = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] irq_level = '0;
    logic insn_boundary = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic [PC_W-1:0] vec_base = 16'h4000;
    logic rte = 1'b0;
    logic dev_ready = 1'b0;
    logic [VEC_W-1:0] dev_vector = '0;
    logic ack_strobe, redirect, supervisor, timeout_abort, stack_overflow;
    logic [2:0] ack_addr, cur_ipl;
    logic [PC_W-1:0] target_pc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [PC_W-1:0] exp_q[$];

    always #4 clk = ~clk;

    lia_entry_unit #(.PC_W(PC_W), .VEC_W(VEC_W), .DEPTH(DEPTH), .ACK_TIMEOUT(TMO)) u_lia_entry_unit (
        .clk(clk), .rst(rst), .irq_level(irq_level), .insn_boundary(insn_boundary),
        .pc_in(pc_in), .vec_base(vec_base), .rte(rte), .dev_ready(dev_ready),
        .dev_vector(dev_vector), .ack_strobe(ack_strobe), .ack_addr(ack_addr),
        .redirect(redirect), .target_pc(target_pc), .cur_ipl(cur_ipl),
        .supervisor(supervisor), .timeout_abort(timeout_abort),
        .stack_overflow(stack_overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every redirect pulse must match the oldest expected target
    always @(negedge clk) begin
        if (!rst && redirect) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4/R6 unexpected redirect actual=%0h expected=none", target_pc);
            end else begin
                chk("R4/R6 redirect target", 32'(target_pc), 32'(exp_q.pop_front()));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic take_irq(input logic [2:0] lvl, input logic [PC_W-1:0] pc,
                            input logic [VEC_W-1:0] vec);
        irq_level = lvl; insn_boundary = 1'b1; pc_in = pc;
        @(posedge clk); @(negedge clk);
        irq_level = '0; insn_boundary = 1'b0;
        chk("R3 strobe", 32'(ack_strobe), 1);
        chk("R3 ack_addr", 32'(ack_addr), 32'(lvl));
        dev_ready = 1'b1; dev_vector = vec;
        exp_q.push_back(vec_base + PC_W'(vec));
        @(posedge clk); @(negedge clk);
        dev_ready = 1'b0;
        chk("R4 strobe dropped", 32'(ack_strobe), 0);
        chk("R5 ipl raised", 32'(cur_ipl), 32'(lvl));
        chk("R5 supervisor", 32'(supervisor), 1);
    endtask

    task automatic refused(input string req, input logic [2:0] lvl, input logic bnd);
        irq_level = lvl; insn_boundary = bnd;
        @(posedge clk); @(negedge clk);
        irq_level = '0; insn_boundary = 1'b0;
        chk(req, 32'(ack_strobe), 0);
    endtask

    task automatic do_rte(input logic [PC_W-1:0] exp_pc, input logic [2:0] exp_ipl,
                          input logic exp_sup);
        rte = 1'b1;
        exp_q.push_back(exp_pc);
        @(posedge clk); @(negedge clk);
        rte = 1'b0;
        chk("R6 ipl restored", 32'(cur_ipl), 32'(exp_ipl));
        chk("R6 sup restored", 32'(supervisor), 32'(exp_sup));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 ipl", 32'(cur_ipl), 0);
        chk("R1 sup", 32'(supervisor), 0);
        chk("R1 strobe", 32'(ack_strobe), 0);
        chk("R1 addr", 32'(ack_addr), 0);
        chk("R1 redirect", 32'(redirect), 0);
        chk("R1 flags", 32'({timeout_abort, stack_overflow}), 0);

        refused("R2 level zero", 3'd0, 1'b1);
        refused("R2 no boundary", 3'd3, 1'b0);

        take_irq(3'd1, 16'h0100, 8'h10);
        refused("R2 equal level", 3'd1, 1'b1);
        take_irq(3'd2, 16'h0200, 8'h20);
        take_irq(3'd3, 16'h0300, 8'h31);
        take_irq(3'd4, 16'h0400, 8'hff);

        // R7: stack full with four entries
        refused("R7 refused when full", 3'd5, 1'b1);
        chk("R7 overflow flag", 32'(stack_overflow), 1);
        chk("R7 ipl unchanged", 32'(cur_ipl), 4);

        do_rte(16'h0400, 3'd3, 1'b1);
        do_rte(16'h0300, 3'd2, 1'b1);
        do_rte(16'h0200, 3'd1, 1'b1);
        do_rte(16'h0100, 3'd0, 1'b0);

        // R6: return on empty stack does nothing
        rte = 1'b1;
        @(posedge clk); @(negedge clk);
        rte = 1'b0;
        chk("R6 empty rte ipl", 32'(cur_ipl), 0);
        chk("R6 empty rte redirect", 32'(redirect), 0);

        // R9: return wins over a same-cycle request
        take_irq(3'd2, 16'h0500, 8'h05);
        rte = 1'b1; irq_level = 3'd6; insn_boundary = 1'b1;
        exp_q.push_back(16'h0500);
        @(posedge clk); @(negedge clk);
        rte = 1'b0; irq_level = '0; insn_boundary = 1'b0;
        chk("R9 no strobe", 32'(ack_strobe), 0);
        chk("R9 ipl restored", 32'(cur_ipl), 0);

        // R8: acknowledge timeout
        irq_level = 3'd3; insn_boundary = 1'b1; pc_in = 16'h0600;
        @(posedge clk); @(negedge clk);
        irq_level = '0; insn_boundary = 1'b0;
        repeat (TMO - 1) @(posedge clk);
        @(negedge clk);
        chk("R8 strobe held", 32'(ack_strobe), 1);
        chk("R8 no abort yet", 32'(timeout_abort), 0);
        @(posedge clk); @(negedge clk);
        chk("R8 strobe dropped", 32'(ack_strobe), 0);
        chk("R8 abort flag", 32'(timeout_abort), 1);
        chk("R8 ipl unchanged", 32'(cur_ipl), 0);
        chk("R8 sup unchanged", 32'(supervisor), 0);
        repeat (3) @(negedge clk);
        chk("R8 abort sticky", 32'(timeout_abort), 1);
        chk("R7 overflow sticky", 32'(stack_overflow), 1);
        chk("R4 all redirects seen", 32'(exp_q.size()), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule